// File: doc/BRIEF.md
# Timer and External Interrupt Flag Register

This block is the control and status byte that holds the interrupt requests of two timers and two external pins. It also holds the trigger mode of each pin and the run bits passed to the timers. Both external pins are active low. Each pin goes through a two-flop synchronizer. Each pin then either sets a latched request on a falling edge, or drives its request straight from its level, as its mode bit selects.

The two timer overflow pulses set their own latched requests. The interrupt controller sends one acknowledge strobe per source when it takes that source's vector. An acknowledge clears the latched requests, but it does not clear a request that follows a level-mode pin.

Software reaches the byte in two ways. It can write the whole byte at the base address. It can also write one bit at a time at the eight bit addresses that start at the base, where bit n is at base+n. Software can raise or clear a latched request this way.

Top module: `tcon_irq_flags`

## Requirements
- R1: While reset is asserted and right after it, the register reads 00h and all requests and run outputs are low.
- R2: The bit positions are 7 = timer 1 request, 6 = timer 1 run, 5 = timer 0 request, 4 = timer 0 run, 3 = external 1 request, 2 = external 1 mode, 1 = external 0 request, 0 = external 0 mode. A byte write at address 88h loads the register, subject to R6. A byte write at any other address is ignored.
- R3: A bit write at address 88h+n (n = 0..7) with value v sets bit n to v, subject to R6. The other seven bits are unchanged.
- R4: When the mode bit of an external source is 1 (edge mode), a high-to-low transition of its pin sets its request. The request appears on the third rising clock edge after the pin goes low. One falling edge gives exactly one set event, so the request does not return while the pin stays low after it has been cleared.
- R5: In edge mode, an acknowledge strobe for that external source clears its request on the next edge.
- R6: When the mode bit is 0 (level mode), the request equals the inverted pin, delayed by three edges. Acknowledge strobes and software writes to that request bit have no effect.
- R7: A timer overflow pulse sets its request on the next edge. The matching acknowledge clears the request on the next edge.
- R8: If a hardware set event (timer overflow or edge-mode falling edge) coincides with an acknowledge or a software write to the same bit, the bit is set.
- R9: The four request outputs and the two run outputs always equal their register bits. A software write of 1 to a timer request or to an edge-mode external request raises that request. A write that coincides with an acknowledge takes precedence over the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_n | input | 1 | External interrupt 0 pin, active low, asynchronous |
| ext1_n | input | 1 | External interrupt 1 pin, active low, asynchronous |
| tmr0_ovf | input | 1 | Timer 0 rollover pulse |
| tmr1_ovf | input | 1 | Timer 1 rollover pulse |
| ack_ext0 | input | 1 | Vector taken for external 0 |
| ack_ext1 | input | 1 | Vector taken for external 1 |
| ack_tmr0 | input | 1 | Vector taken for timer 0 |
| ack_tmr1 | input | 1 | Vector taken for timer 1 |
| sfr_addr | input | 8 | Register or bit address |
| sfr_wr_byte | input | 1 | Byte write strobe |
| sfr_wr_bit | input | 1 | Single-bit write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_bit_val | input | 1 | Single-bit write value |
| flags | output | 8 | Current register value |
| req_ext0 | output | 1 | External 0 request |
| req_ext1 | output | 1 | External 1 request |
| req_tmr0 | output | 1 | Timer 0 request |
| req_tmr1 | output | 1 | Timer 1 request |
| run0 | output | 1 | Timer 0 run control |
| run1 | output | 1 | Timer 1 run control |

## Verification
The collision that matters most is a hardware set event that lands in the same cycle as a vector acknowledge or a software write to the same flag. The bench provokes it in three ways. It asserts a timer acknowledge together with the rollover pulse. It holds an external acknowledge high while a falling edge moves through the synchronizer. It then runs a long stretch of random pin, pulse, strobe and write traffic. A behavioural model applies the stated precedence (set event, then write, then acknowledge) at every edge, and the bench compares the full byte and every output with it on each clock.

// File: rtl/tcon_irq_flags.sv
module tcon_irq_flags #(
  parameter logic [7:0] BASE_ADDR = 8'h88
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext0_n,
  input  logic       ext1_n,
  input  logic       tmr0_ovf,
  input  logic       tmr1_ovf,
  input  logic       ack_ext0,
  input  logic       ack_ext1,
  input  logic       ack_tmr0,
  input  logic       ack_tmr1,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr_byte,
  input  logic       sfr_wr_bit,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_bit_val,
  output logic [7:0] flags,
  output logic       req_ext0,
  output logic       req_ext1,
  output logic       req_tmr0,
  output logic       req_tmr1,
  output logic       run0,
  output logic       run1
);
  localparam int B_MODE0 = 0, B_REQE0 = 1, B_MODE1 = 2, B_REQE1 = 3;
  localparam int B_RUN0  = 4, B_REQT0 = 5, B_RUN1  = 6, B_REQT1 = 7;

  // [0] first stage, [1] synchronized sample, [2] previous sample
  logic [2:0] sh0, sh1;
  logic       fall0, fall1;
  logic [7:0] wr_hit, wr_val, nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh0 <= 3'b111;
      sh1 <= 3'b111;
    end else begin
      sh0 <= {sh0[1:0], ext0_n};
      sh1 <= {sh1[1:0], ext1_n};
    end

  assign fall0 = sh0[2] & ~sh0[1];
  assign fall1 = sh1[2] & ~sh1[1];

  always_comb begin
    wr_hit = '0;
    wr_val = '0;
    if (sfr_wr_byte && sfr_addr == BASE_ADDR) begin
      wr_hit = 8'hFF;
      wr_val = sfr_wdata;
    end else if (sfr_wr_bit && sfr_addr[7:3] == BASE_ADDR[7:3]) begin
      wr_hit[sfr_addr[2:0]] = 1'b1;
      wr_val[sfr_addr[2:0]] = sfr_bit_val;
    end
  end

  always_comb begin
    nxt = flags;
    for (int i = 0; i < 8; i += 2)
      if (wr_hit[i]) nxt[i] = wr_val[i];

    if (tmr0_ovf)              nxt[B_REQT0] = 1'b1;
    else if (wr_hit[B_REQT0])  nxt[B_REQT0] = wr_val[B_REQT0];
    else if (ack_tmr0)         nxt[B_REQT0] = 1'b0;

    if (tmr1_ovf)              nxt[B_REQT1] = 1'b1;
    else if (wr_hit[B_REQT1])  nxt[B_REQT1] = wr_val[B_REQT1];
    else if (ack_tmr1)         nxt[B_REQT1] = 1'b0;

    if (!flags[B_MODE0])       nxt[B_REQE0] = ~sh0[1];
    else if (fall0)            nxt[B_REQE0] = 1'b1;
    else if (wr_hit[B_REQE0])  nxt[B_REQE0] = wr_val[B_REQE0];
    else if (ack_ext0)         nxt[B_REQE0] = 1'b0;

    if (!flags[B_MODE1])       nxt[B_REQE1] = ~sh1[1];
    else if (fall1)            nxt[B_REQE1] = 1'b1;
    else if (wr_hit[B_REQE1])  nxt[B_REQE1] = wr_val[B_REQE1];
    else if (ack_ext1)         nxt[B_REQE1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= 8'h00;
    else        flags <= nxt;

  assign req_ext0 = flags[B_REQE0];
  assign req_ext1 = flags[B_REQE1];
  assign req_tmr0 = flags[B_REQT0];
  assign req_tmr1 = flags[B_REQT1];
  assign run0     = flags[B_RUN0];
  assign run1     = flags[B_RUN1];

  // R8
  tmr0_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_ovf |=> req_tmr0);

  // R7
  tmr1_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tmr1 && !tmr1_ovf && !wr_hit[B_REQT1]) |=> !req_tmr1);

  // R4
  ext0_edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[B_MODE0] && fall0) |=> req_ext0);

  // R5
  ext1_edge_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[B_MODE1] && ack_ext1 && !fall1 && !wr_hit[B_REQE1]) |=> !req_ext1);

  // R6
  ext0_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[B_MODE0] && !sh0[1] && ack_ext0) |=> req_ext0);
endmodule

// File: tb/tcon_irq_flags_test.sv
`timescale 1ns/1ps
module tcon_irq_flags_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext0_n = 1'b1, ext1_n = 1'b1;
  logic tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
  logic ack_ext0 = 1'b0, ack_ext1 = 1'b0, ack_tmr0 = 1'b0, ack_tmr1 = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic sfr_wr_byte = 1'b0, sfr_wr_bit = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic sfr_bit_val = 1'b0;
  logic [7:0] flags;
  logic req_ext0, req_ext1, req_tmr0, req_tmr1, run0, run1;

  int tests = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  tcon_irq_flags uut (
    .clk(clk), .rst_n(rst_n), .ext0_n(ext0_n), .ext1_n(ext1_n),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .ack_ext0(ack_ext0), .ack_ext1(ack_ext1), .ack_tmr0(ack_tmr0), .ack_tmr1(ack_tmr1),
    .sfr_addr(sfr_addr), .sfr_wr_byte(sfr_wr_byte), .sfr_wr_bit(sfr_wr_bit),
    .sfr_wdata(sfr_wdata), .sfr_bit_val(sfr_bit_val),
    .flags(flags), .req_ext0(req_ext0), .req_ext1(req_ext1),
    .req_tmr0(req_tmr0), .req_tmr1(req_tmr1), .run0(run0), .run1(run1));

  // behavioural reference
  logic [7:0] m;
  bit h0[$], h1[$];

  function automatic bit ext_next(bit mode, bit cur, bit sync_pin, bit prev_pin,
                                  bit hit, bit val, bit ack);
    if (!mode) return !sync_pin;
    if (prev_pin && !sync_pin) return 1'b1;
    if (hit) return val;
    if (ack) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = 8'h00;
      h0 = '{1'b1, 1'b1, 1'b1};
      h1 = '{1'b1, 1'b1, 1'b1};
    end else begin
      logic [7:0] hit, val, n;
      hit = 0; val = 0; n = m;
      if (sfr_wr_byte && sfr_addr == 8'h88) begin hit = 8'hFF; val = sfr_wdata; end
      else if (sfr_wr_bit && sfr_addr >= 8'h88 && sfr_addr <= 8'h8F) begin
        hit[sfr_addr - 8'h88] = 1'b1;
        val[sfr_addr - 8'h88] = sfr_bit_val;
      end
      foreach (hit[i]) if (i % 2 == 0 && hit[i]) n[i] = val[i];
      n[5] = tmr0_ovf ? 1'b1 : hit[5] ? val[5] : ack_tmr0 ? 1'b0 : m[5];
      n[7] = tmr1_ovf ? 1'b1 : hit[7] ? val[7] : ack_tmr1 ? 1'b0 : m[7];
      n[1] = ext_next(m[0], m[1], h0[1], h0[2], hit[1], val[1], ack_ext0);
      n[3] = ext_next(m[2], m[3], h1[1], h1[2], hit[3], val[3], ack_ext1);
      m = n;
      h0.push_front(ext0_n); void'(h0.pop_back());
      h1.push_front(ext1_n); void'(h1.pop_back());
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(phase, flags, m);
    check("R9", {2'b00, run1, run0, req_tmr1, req_tmr0, req_ext1, req_ext0},
          {2'b00, m[6], m[4], m[7], m[5], m[3], m[1]});
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic idle();
    tmr0_ovf = 0; tmr1_ovf = 0; ack_ext0 = 0; ack_ext1 = 0; ack_tmr0 = 0; ack_tmr1 = 0;
    sfr_wr_byte = 0; sfr_wr_bit = 0;
  endtask

  task automatic bwr(logic [7:0] a, logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr_byte = 1; step(); sfr_wr_byte = 0;
  endtask

  task automatic bitwr(logic [7:0] a, bit v);
    sfr_addr = a; sfr_bit_val = v; sfr_wr_bit = 1; step(); sfr_wr_bit = 0;
  endtask

  initial begin
    #200;
    check("R1", flags, 8'h00);
    @(posedge clk); #1 rst_n = 1;
    step(2);
    check("R1", flags, 8'h00);

    phase = "R2";
    bwr(8'h88, 8'h55); step();
    check("R2", flags, 8'h55);
    bwr(8'h89, 8'hFF); step();
    check("R2", flags, 8'h55);
    bwr(8'h88, 8'h00); step(4);

    phase = "R3";
    for (int i = 0; i < 8; i++) begin bitwr(8'h88 + 8'(i), 1); step(); end
    for (int i = 7; i >= 0; i -= 2) begin bitwr(8'h88 + 8'(i), 0); step(); end
    bitwr(8'h90, 1); step(4);

    phase = "R4";
    bitwr(8'h88, 1); step();
    ext0_n = 0; step(2);
    check("R4", {7'd0, req_ext0}, 8'h00);
    step();
    check("R4", {7'd0, req_ext0}, 8'h01);
    phase = "R5";
    ack_ext0 = 1; step(); ack_ext0 = 0; step(5);
    check("R4", {7'd0, req_ext0}, 8'h00);
    ext0_n = 1; step(4);

    phase = "R8";
    ack_ext0 = 1; ext0_n = 0; step(6); ack_ext0 = 0; step(2);
    ext0_n = 1; tmr0_ovf = 1; ack_tmr0 = 1; step(); idle(); step();
    check("R8", {7'd0, req_tmr0}, 8'h01);
    tmr1_ovf = 1; bitwr(8'h8F, 0); idle(); step();

    phase = "R6";
    bitwr(8'h8A, 0); step();
    ext1_n = 0; step(4);
    check("R6", {7'd0, req_ext1}, 8'h01);
    ack_ext1 = 1; step(3); ack_ext1 = 0;
    bitwr(8'h8B, 0); step();
    check("R6", {7'd0, req_ext1}, 8'h01);
    ext1_n = 1; step(4);
    bitwr(8'h8B, 1); step(2);

    phase = "R7";
    tmr1_ovf = 1; step(); tmr1_ovf = 0; step(2);
    ack_tmr1 = 1; step(); ack_tmr1 = 0; step(2);
    ack_tmr0 = 1; step(); ack_tmr0 = 0; step(2);

    phase = "R9";
    bitwr(8'h8D, 1); step();
    bitwr(8'h89, 1); step();
    sfr_addr = 8'h89; sfr_bit_val = 1; sfr_wr_bit = 1; ack_ext0 = 1; step(); idle(); step(2);
    bwr(8'h88, 8'h50); step(2);

    phase = "R8";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom;
      ext0_n = r[0] | r[1]; ext1_n = r[2] | r[3];
      tmr0_ovf = (r[7:4] == 0); tmr1_ovf = (r[11:8] == 0);
      ack_ext0 = r[12]; ack_ext1 = r[13]; ack_tmr0 = r[14]; ack_tmr1 = r[15];
      sfr_addr = 8'h86 + 8'(r[19:16] % 12);
      sfr_wdata = 8'(r[27:20]);
      sfr_bit_val = r[28];
      sfr_wr_byte = (r[31:29] == 0);
      sfr_wr_bit = (r[31:29] == 1);
      step();
    end
    idle(); step(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule